// File: doc/BRIEF.md
# Multi-Condition Break Controller

This block watches a small processor's fetch stream, data bus and register file, and raises one break request when any of several independently enabled conditions is met. Five sources are available: a single program-address breakpoint, an ordered three-address sequence whose last address must be seen a programmed number of times, a data-access match, a register-value match, and an active-low external break pin. Each request carries a tag that says whether it takes effect before the current instruction (`brk_pre` = 1) or after it (`brk_pre` = 0).

All match settings arrive as static configuration ports held by the surrounding debug logic. Matching only happens while `run` is high. While the interrupt-acknowledge line is low, a break is held back. It is issued once that line returns high, so it lands on the first instruction of the handler.

Top module: `brk_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `brk_req` is 0.
- R2: With `src_en[0]` set, a cycle with `fetch_vld` high and `fetch_pc` equal to `bp_pc` gives `brk_req` = 1 with `brk_pre` = 1 in the next cycle. Other addresses give no break.
- R3: With `src_en[1]` set, the sequence advances only in this order: a fetch of `seq_pc1` arms it, and then a fetch of `seq_pc2` arms it further. A fetch of `seq_pc3` before both stages are armed neither counts nor fires.
- R4: Once armed, the sequence fires (with `brk_pre` = 1, in the cycle after the fetch) on the N-th fetch of `seq_pc3`, where N = `seq_pass`, and 0 is taken as 1. After firing it returns to its initial state, so a further `seq_pc3` fetch does not fire.
- R5: A one-cycle `run_start` pulse returns the sequence to its initial state and clears its count.
- R6: With `src_en[2]` set, a cycle with `dacc_vld` high fires in the next cycle with `brk_pre` = 0 when all three of these hold: `dm_lo` ≤ `dacc_addr` ≤ `dm_hi` (both limits inclusive); `dacc_data` equals `dm_val` on every bit set in `dm_mask`; and, if `dm_dir_care` is 1, `dacc_wr` equals `dm_dir` (1 = write).
- R7: With `src_en[3]` set, a cycle with `rc_vld` high fires in the next cycle with `brk_pre` = 0 when A, B, the flags {E,I,C,Z} (bit 3 down to bit 0), X and Y each equal their reference on every bit set in that field's mask.
- R8: Each source bit of `src_en` (0 PC, 1 sequence, 2 data, 3 register, 4 external) is independent. A matching event on a disabled source gives no break, and the request is the OR of the enabled matches.
- R9: With `src_en[4]` set, a high-to-low change on `ext_brk_n` passes through a two-flop synchronizer. It gives `brk_req` with `brk_pre` = 0 three rising edges after the change. A low level that is held gives only one break.
- R10: While `irq_ack_n` is low, `brk_req` stays 0 and any match is remembered. In the cycle after `irq_ack_n` is high again, the held break is issued with `brk_pre` = 1.
- R11: While `run` is low, no break is raised and any held break is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Program is executing |
| run_start | input | 1 | One-cycle pulse at start of execution |
| src_en | input | 5 | Per-source enables |
| irq_ack_n | input | 1 | Interrupt acknowledge, active low |
| ext_brk_n | input | 1 | External break pin, asynchronous, active low |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_pc | input | PC_W | Fetch address |
| bp_pc | input | PC_W | Breakpoint address |
| seq_pc1 | input | PC_W | Sequence first address |
| seq_pc2 | input | PC_W | Sequence second address |
| seq_pc3 | input | PC_W | Sequence final address |
| seq_pass | input | PASS_W | Required passes through final address |
| dacc_vld | input | 1 | Data access strobe |
| dacc_addr | input | DA_W | Data access address |
| dacc_data | input | DW | Data access value |
| dacc_wr | input | 1 | Access direction, 1 = write |
| dm_lo | input | DA_W | Lower address limit |
| dm_hi | input | DA_W | Upper address limit |
| dm_val | input | DW | Data reference |
| dm_mask | input | DW | Data compare mask, 1 = compare |
| dm_dir | input | 1 | Reference direction |
| dm_dir_care | input | 1 | 1 = direction must match |
| rc_vld | input | 1 | Instruction completed, register values valid |
| rc_a | input | NW | Register A |
| rc_b | input | NW | Register B |
| rc_flags | input | 4 | Flags {E,I,C,Z} |
| rc_x | input | XW | Register X |
| rc_y | input | XW | Register Y |
| rm_a | input | NW | A reference |
| rm_a_mask | input | NW | A mask |
| rm_b | input | NW | B reference |
| rm_b_mask | input | NW | B mask |
| rm_flags | input | 4 | Flag reference |
| rm_flags_mask | input | 4 | Flag mask |
| rm_x | input | XW | X reference |
| rm_x_mask | input | XW | X mask |
| rm_y | input | XW | Y reference |
| rm_y_mask | input | XW | Y mask |
| brk_req | output | 1 | Break request, one cycle per break |
| brk_pre | output | 1 | 1 = before the instruction, 0 = after |

## Verification
The sequence state is the part most likely to hide faults. A stage that advances out of order shows up as a break at the wrong `seq_pc3` fetch. A pass counter that is off by one moves the break one fetch earlier or later. A stage that is not cleared shows up as a spurious break right after `run_start` or right after a firing. A deferral register that leaks shows a request while `irq_ack_n` is low. A deferral register that forgets shows no request in the cycle after release. A synchronizer of the wrong depth moves the external break by a whole cycle. Each of these faults shows at `brk_req`/`brk_pre` within one cycle of the stimulus that exposes it, so the bench compares against an expected cycle and an expected tag.

// File: rtl/brk_pkg.sv
// Shared definitions for the break controller: source indices and the
// sequencer stage encoding. Assumes a five-source enable vector.
package brk_pkg;
    localparam int SRC_PC   = 0;
    localparam int SRC_SEQ  = 1;
    localparam int SRC_DATA = 2;
    localparam int SRC_REG  = 3;
    localparam int SRC_EXT  = 4;
    localparam int N_SRC    = 5;

    typedef enum logic [1:0] {
        SQ_WAIT1 = 2'd0,
        SQ_WAIT2 = 2'd1,
        SQ_COUNT = 2'd2
    } seq_stage_t;
endpackage

// File: rtl/brk_sync_fall.sv
// Synchronizes an asynchronous active-low pin through STAGES flops and
// flags one cycle on each high-to-low transition of the synchronized value.
// Assumes the pin idles high; the chain resets to all ones.
module brk_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    // Shift the pin into the synchronizer and keep one extra flop for edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[LAST-1:0], pin_n};
    end

    assign fall = chain[LAST] & ~chain[LAST-1];

    // R9: an edge pulse lasts exactly one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/brk_seq.sv
// Ordered three-address program-counter sequencer. It arms on addr1, then on
// addr2, then counts fetches of addr3 until the pass count is reached.
// Assumes one fetch per strobe; clr has priority over all advancing.
module brk_seq
    import brk_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PASS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              fetch_vld,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [PC_W-1:0]   pc1,
    input  logic [PC_W-1:0]   pc2,
    input  logic [PC_W-1:0]   pc3,
    input  logic [PASS_W-1:0] pass,
    output logic              fire
);
    localparam int CW = PASS_W + 1;

    seq_stage_t        stage;
    logic [PASS_W-1:0] cnt;
    logic [CW-1:0]     need;
    logic [CW-1:0]     seen;
    logic              step;
    logic              last;

    assign step = en && fetch_vld;
    assign need = (pass == '0) ? CW'(1) : {1'b0, pass};
    assign seen = {1'b0, cnt} + CW'(1);
    assign last = (seen >= need);
    assign fire = step && (stage == SQ_COUNT) && (fetch_pc == pc3) && last;

    // Advance the stage in strict order, count final-address passes, rearm on fire.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stage <= SQ_WAIT1;
            cnt   <= '0;
        end else if (step) begin
            unique case (stage)
                SQ_WAIT1: if (fetch_pc == pc1) stage <= SQ_WAIT2;
                SQ_WAIT2: if (fetch_pc == pc2) begin
                    stage <= SQ_COUNT;
                    cnt   <= '0;
                end
                SQ_COUNT: if (fetch_pc == pc3) begin
                    if (last) begin
                        stage <= SQ_WAIT1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: stage <= SQ_WAIT1;
            endcase
        end
    end

    // R4: after firing the sequencer is back at its first stage
    a_r4_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (stage == SQ_WAIT1));
    // R3: the counting stage is never reached straight from the first stage
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == SQ_WAIT1) |=> (stage != SQ_COUNT));
    // R5: a clear returns stage and count to their initial values
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stage == SQ_WAIT1) && (cnt == '0));
endmodule

// File: rtl/brk_dmatch.sv
// Data-access comparator: inclusive address window, bit-masked data value
// and optional direction check, all ANDed with the access strobe.
// Assumes lo <= hi for a usable window.
module brk_dmatch #(
    parameter int AW = 16,
    parameter int DW = 4
) (
    input  logic          vld,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          wr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] mask,
    input  logic          dir,
    input  logic          dir_care,
    output logic          hit
);
    logic in_win;
    logic data_ok;
    logic dir_ok;

    // Combine window, masked value and direction into one match.
    always_comb begin
        in_win  = (addr >= lo) && (addr <= hi);
        data_ok = ((data ^ val) & mask) == '0;
        dir_ok  = !dir_care || (wr == dir);
        hit     = vld && in_win && data_ok && dir_ok;
    end
endmodule

// File: rtl/brk_rmatch.sv
// Register-value comparator: each field is compared only on its mask bits
// and all fields are ANDed with the instruction-complete strobe.
// Assumes the flag field is four bits {E,I,C,Z}.
module brk_rmatch #(
    parameter int NW = 4,
    parameter int XW = 8
) (
    input  logic          vld,
    input  logic [NW-1:0] a,
    input  logic [NW-1:0] b,
    input  logic [3:0]    f,
    input  logic [XW-1:0] x,
    input  logic [XW-1:0] y,
    input  logic [NW-1:0] ra,
    input  logic [NW-1:0] ma,
    input  logic [NW-1:0] rb,
    input  logic [NW-1:0] mb,
    input  logic [3:0]    rf,
    input  logic [3:0]    mf,
    input  logic [XW-1:0] rx,
    input  logic [XW-1:0] mx,
    input  logic [XW-1:0] ry,
    input  logic [XW-1:0] my,
    output logic          hit
);
    localparam int TW = 2 * NW + 4 + 2 * XW;

    logic [TW-1:0] cur;
    logic [TW-1:0] ref_v;
    logic [TW-1:0] msk;

    // Pack all fields so one masked compare covers every register.
    always_comb begin
        cur   = {a, b, f, x, y};
        ref_v = {ra, rb, rf, rx, ry};
        msk   = {ma, mb, mf, mx, my};
        hit   = vld && (((cur ^ ref_v) & msk) == '0);
    end
endmodule

// File: rtl/brk_unit.sv
// Break controller top. Gathers five enabled match sources, tags the request
// as before/after the instruction, and holds any break while interrupt
// acknowledge is low, releasing it tagged "before" for the handler entry.
// Assumes configuration ports are static while run is high.
module brk_unit
    import brk_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int DA_W     = 16,
    parameter int DW       = 4,
    parameter int NW       = 4,
    parameter int XW       = 8,
    parameter int PASS_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              run_start,
    input  logic [4:0]        src_en,
    input  logic              irq_ack_n,
    input  logic              ext_brk_n,
    input  logic              fetch_vld,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [PC_W-1:0]   bp_pc,
    input  logic [PC_W-1:0]   seq_pc1,
    input  logic [PC_W-1:0]   seq_pc2,
    input  logic [PC_W-1:0]   seq_pc3,
    input  logic [PASS_W-1:0] seq_pass,
    input  logic              dacc_vld,
    input  logic [DA_W-1:0]   dacc_addr,
    input  logic [DW-1:0]     dacc_data,
    input  logic              dacc_wr,
    input  logic [DA_W-1:0]   dm_lo,
    input  logic [DA_W-1:0]   dm_hi,
    input  logic [DW-1:0]     dm_val,
    input  logic [DW-1:0]     dm_mask,
    input  logic              dm_dir,
    input  logic              dm_dir_care,
    input  logic              rc_vld,
    input  logic [NW-1:0]     rc_a,
    input  logic [NW-1:0]     rc_b,
    input  logic [3:0]        rc_flags,
    input  logic [XW-1:0]     rc_x,
    input  logic [XW-1:0]     rc_y,
    input  logic [NW-1:0]     rm_a,
    input  logic [NW-1:0]     rm_a_mask,
    input  logic [NW-1:0]     rm_b,
    input  logic [NW-1:0]     rm_b_mask,
    input  logic [3:0]        rm_flags,
    input  logic [3:0]        rm_flags_mask,
    input  logic [XW-1:0]     rm_x,
    input  logic [XW-1:0]     rm_x_mask,
    input  logic [XW-1:0]     rm_y,
    input  logic [XW-1:0]     rm_y_mask,
    output logic              brk_req,
    output logic              brk_pre
);
    logic [N_SRC-1:0] raw;
    logic [N_SRC-1:0] hits;
    logic             any_hit;
    logic             pre_hit;
    logic             pend;

    assign raw[SRC_PC] = fetch_vld && (fetch_pc == bp_pc);

    brk_seq #(.PC_W(PC_W), .PASS_W(PASS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (run_start),
        .en        (run && src_en[SRC_SEQ]),
        .fetch_vld (fetch_vld),
        .fetch_pc  (fetch_pc),
        .pc1       (seq_pc1),
        .pc2       (seq_pc2),
        .pc3       (seq_pc3),
        .pass      (seq_pass),
        .fire      (raw[SRC_SEQ])
    );

    brk_dmatch #(.AW(DA_W), .DW(DW)) u_dm (
        .vld      (dacc_vld),
        .addr     (dacc_addr),
        .data     (dacc_data),
        .wr       (dacc_wr),
        .lo       (dm_lo),
        .hi       (dm_hi),
        .val      (dm_val),
        .mask     (dm_mask),
        .dir      (dm_dir),
        .dir_care (dm_dir_care),
        .hit      (raw[SRC_DATA])
    );

    brk_rmatch #(.NW(NW), .XW(XW)) u_rm (
        .vld (rc_vld),
        .a   (rc_a),
        .b   (rc_b),
        .f   (rc_flags),
        .x   (rc_x),
        .y   (rc_y),
        .ra  (rm_a),
        .ma  (rm_a_mask),
        .rb  (rm_b),
        .mb  (rm_b_mask),
        .rf  (rm_flags),
        .mf  (rm_flags_mask),
        .rx  (rm_x),
        .mx  (rm_x_mask),
        .ry  (rm_y),
        .my  (rm_y_mask),
        .hit (raw[SRC_REG])
    );

    brk_sync_fall #(.STAGES(SYNC_STG)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_brk_n),
        .fall  (raw[SRC_EXT])
    );

    // Gate each raw match with its enable and with run.
    always_comb begin
        hits    = raw & src_en & {N_SRC{run}};
        any_hit = |hits;
        pre_hit = hits[SRC_PC] | hits[SRC_SEQ];
    end

    // Issue, defer during interrupt acknowledge, or drop when not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req <= 1'b0;
            brk_pre <= 1'b0;
            pend    <= 1'b0;
        end else if (!run) begin
            brk_req <= 1'b0;
            brk_pre <= 1'b0;
            pend    <= 1'b0;
        end else if (!irq_ack_n) begin
            brk_req <= 1'b0;
            pend    <= pend | any_hit;
        end else if (pend || any_hit) begin
            brk_req <= 1'b1;
            brk_pre <= pend | pre_hit;
            pend    <= 1'b0;
        end else begin
            brk_req <= 1'b0;
        end
    end

    // R11: nothing is requested after a cycle with run low
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !brk_req);
    // R10: no request follows a cycle with interrupt acknowledge active
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack_n |=> !brk_req);
    // R10: a held break is released, tagged before, once acknowledge ends
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        run && irq_ack_n && pend |=> brk_req && brk_pre);
    // R2: an enabled breakpoint fetch is requested before execution
    a_r2_pc_pre: assert property (@(posedge clk) disable iff (!rst_n)
        run && irq_ack_n && src_en[SRC_PC] && fetch_vld && (fetch_pc == bp_pc)
        |=> brk_req && brk_pre);
endmodule

// File: tb/test_brk_unit.sv
// Scoreboard bench: driver tasks push expected breaks (cycle, tag, label);
// a monitor on the falling edge pops and compares them against brk_req/brk_pre.
module test_brk_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        run_start = 1'b0;
    logic [4:0]  src_en = '0;
    logic        irq_ack_n = 1'b1;
    logic        ext_brk_n = 1'b1;
    logic        fetch_vld = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic [15:0] bp_pc = 16'h0200;
    logic [15:0] seq_pc1 = 16'h0010;
    logic [15:0] seq_pc2 = 16'h0020;
    logic [15:0] seq_pc3 = 16'h0030;
    logic [7:0]  seq_pass = 8'd3;
    logic        dacc_vld = 1'b0;
    logic [15:0] dacc_addr = '0;
    logic [3:0]  dacc_data = '0;
    logic        dacc_wr = 1'b0;
    logic [15:0] dm_lo = 16'h0040;
    logic [15:0] dm_hi = 16'h004F;
    logic [3:0]  dm_val = 4'hA;
    logic [3:0]  dm_mask = 4'hE;
    logic        dm_dir = 1'b1;
    logic        dm_dir_care = 1'b1;
    logic        rc_vld = 1'b0;
    logic [3:0]  rc_a = '0;
    logic [3:0]  rc_b = '0;
    logic [3:0]  rc_flags = '0;
    logic [7:0]  rc_x = '0;
    logic [7:0]  rc_y = '0;
    logic [3:0]  rm_a = 4'h5;
    logic [3:0]  rm_a_mask = 4'hF;
    logic [3:0]  rm_b = 4'h0;
    logic [3:0]  rm_b_mask = 4'h0;
    logic [3:0]  rm_flags = 4'b0100;
    logic [3:0]  rm_flags_mask = 4'b0100;
    logic [7:0]  rm_x = 8'h3C;
    logic [7:0]  rm_x_mask = 8'hF0;
    logic [7:0]  rm_y = 8'h00;
    logic [7:0]  rm_y_mask = 8'h00;
    logic        brk_req;
    logic        brk_pre;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    unexp = 0;
    string phase = "R1";
    int    q_cyc[$];
    bit    q_pre[$];
    string q_tag[$];

    brk_unit i_brk_unit (
        .clk(clk), .rst_n(rst_n), .run(run), .run_start(run_start),
        .src_en(src_en), .irq_ack_n(irq_ack_n), .ext_brk_n(ext_brk_n),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .bp_pc(bp_pc),
        .seq_pc1(seq_pc1), .seq_pc2(seq_pc2), .seq_pc3(seq_pc3), .seq_pass(seq_pass),
        .dacc_vld(dacc_vld), .dacc_addr(dacc_addr), .dacc_data(dacc_data),
        .dacc_wr(dacc_wr), .dm_lo(dm_lo), .dm_hi(dm_hi), .dm_val(dm_val),
        .dm_mask(dm_mask), .dm_dir(dm_dir), .dm_dir_care(dm_dir_care),
        .rc_vld(rc_vld), .rc_a(rc_a), .rc_b(rc_b), .rc_flags(rc_flags),
        .rc_x(rc_x), .rc_y(rc_y), .rm_a(rm_a), .rm_a_mask(rm_a_mask),
        .rm_b(rm_b), .rm_b_mask(rm_b_mask), .rm_flags(rm_flags),
        .rm_flags_mask(rm_flags_mask), .rm_x(rm_x), .rm_x_mask(rm_x_mask),
        .rm_y(rm_y), .rm_y_mask(rm_y_mask), .brk_req(brk_req), .brk_pre(brk_pre)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each observed break with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
                n_chk++; n_bad++;
                $display("FAIL %s missed break: brk_req=0 expected 1", q_tag[0]);
                void'(q_cyc.pop_front()); void'(q_pre.pop_front()); void'(q_tag.pop_front());
            end
            if (brk_req) begin
                n_chk++;
                if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                    if (brk_pre !== q_pre[0]) begin
                        n_bad++;
                        $display("FAIL %s brk_pre=%0b expected %0b", q_tag[0], brk_pre, q_pre[0]);
                    end
                    void'(q_cyc.pop_front()); void'(q_pre.pop_front()); void'(q_tag.pop_front());
                end else begin
                    n_bad++; unexp++;
                    $display("FAIL %s unexpected break: brk_req=1 expected 0", phase);
                end
            end
        end
    end

    task automatic expect_brk(input int at, input bit pre, input string tag);
        q_cyc.push_back(at); q_pre.push_back(pre); q_tag.push_back(tag);
    endtask

    task automatic do_fetch(input logic [15:0] pc, input bit exp, input string tag);
        fetch_pc = pc; fetch_vld = 1'b1;
        if (exp) expect_brk(cyc + 1, 1'b1, tag);
        @(negedge clk); fetch_vld = 1'b0;
    endtask

    task automatic do_dacc(input logic [15:0] a, input logic [3:0] d, input logic w,
                           input bit exp, input string tag);
        dacc_addr = a; dacc_data = d; dacc_wr = w; dacc_vld = 1'b1;
        if (exp) expect_brk(cyc + 1, 1'b0, tag);
        @(negedge clk); dacc_vld = 1'b0;
    endtask

    task automatic do_regs(input logic [3:0] a, input logic [3:0] b, input logic [3:0] f,
                           input logic [7:0] x, input logic [7:0] y,
                           input bit exp, input string tag);
        rc_a = a; rc_b = b; rc_flags = f; rc_x = x; rc_y = y; rc_vld = 1'b1;
        if (exp) expect_brk(cyc + 1, 1'b0, tag);
        @(negedge clk); rc_vld = 1'b0;
    endtask

    // One check: no unexpected break and nothing outstanding over n cycles.
    task automatic quiet(input int n, input string tag);
        int u0;
        u0 = unexp;
        repeat (n) @(negedge clk);
        #1;
        n_chk++;
        if (unexp != u0 || q_cyc.size() != 0) begin
            n_bad++;
            $display("FAIL %s quiet window: breaks=%0d pending=%0d expected 0 0",
                     tag, unexp - u0, q_cyc.size());
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: running=1 expected 0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        n_chk++;
        if (brk_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset brk_req=%0b expected 0", brk_req);
        end
        rst_n = 1'b1; run = 1'b1;
        @(negedge clk);

        // R2 breakpoint, R8 disabled source
        phase = "R2"; src_en = 5'b00001;
        do_fetch(16'h0200, 1'b1, "R2 bp hit");
        do_fetch(16'h0201, 1'b0, "R2 other pc");
        quiet(3, "R2 no extra");
        phase = "R8"; src_en = 5'b00000;
        do_fetch(16'h0200, 1'b0, "R8 pc disabled");
        quiet(3, "R8 pc disabled");

        // R3 order, R4 pass count and rearm
        phase = "R3"; src_en = 5'b00010;
        do_fetch(16'h0030, 1'b0, "R3"); do_fetch(16'h0020, 1'b0, "R3");
        do_fetch(16'h0030, 1'b0, "R3"); do_fetch(16'h0010, 1'b0, "R3");
        do_fetch(16'h0030, 1'b0, "R3 early pc3");
        quiet(2, "R3 out of order");
        phase = "R4";
        do_fetch(16'h0020, 1'b0, "R4"); do_fetch(16'h0030, 1'b0, "R4");
        do_fetch(16'h0055, 1'b0, "R4"); do_fetch(16'h0030, 1'b0, "R4");
        do_fetch(16'h0030, 1'b1, "R4 third pass");
        do_fetch(16'h0030, 1'b0, "R4 rearmed");
        quiet(2, "R4 rearm");

        // R5 run_start clears the sequence
        phase = "R5";
        do_fetch(16'h0010, 1'b0, "R5"); do_fetch(16'h0020, 1'b0, "R5");
        do_fetch(16'h0030, 1'b0, "R5");
        run_start = 1'b1; @(negedge clk); run_start = 1'b0;
        do_fetch(16'h0030, 1'b0, "R5"); do_fetch(16'h0030, 1'b0, "R5");
        do_fetch(16'h0030, 1'b0, "R5");
        quiet(2, "R5 cleared");
        seq_pass = 8'd0;
        do_fetch(16'h0010, 1'b0, "R4"); do_fetch(16'h0020, 1'b0, "R4");
        do_fetch(16'h0030, 1'b1, "R4 pass zero as one");
        quiet(2, "R4 pass zero");

        // R6 data access
        phase = "R6"; src_en = 5'b00100;
        do_dacc(16'h0040, 4'hA, 1'b1, 1'b1, "R6 low limit");
        do_dacc(16'h004F, 4'hB, 1'b1, 1'b1, "R6 high limit masked bit");
        do_dacc(16'h0050, 4'hA, 1'b1, 1'b0, "R6 above");
        do_dacc(16'h003F, 4'hA, 1'b1, 1'b0, "R6 below");
        do_dacc(16'h0045, 4'h2, 1'b1, 1'b0, "R6 data");
        do_dacc(16'h0045, 4'hA, 1'b0, 1'b0, "R6 dir");
        quiet(2, "R6 misses");
        dm_dir_care = 1'b0;
        do_dacc(16'h0045, 4'hA, 1'b0, 1'b1, "R6 dir ignored");
        quiet(2, "R6 after");

        // R7 register match
        phase = "R7"; src_en = 5'b01000;
        do_regs(4'h5, 4'h9, 4'b0100, 8'h3A, 8'h07, 1'b1, "R7 match");
        do_regs(4'h4, 4'h9, 4'b0100, 8'h3A, 8'h07, 1'b0, "R7 a");
        do_regs(4'h5, 4'h9, 4'b0000, 8'h3A, 8'h07, 1'b0, "R7 flag i");
        do_regs(4'h5, 4'h9, 4'b0100, 8'h4C, 8'h07, 1'b0, "R7 x");
        quiet(2, "R7 misses");
        do_regs(4'h5, 4'h0, 4'b1111, 8'h3F, 8'hFF, 1'b1, "R7 masked fields");
        quiet(2, "R7 after");

        // R9 external pin
        phase = "R9"; src_en = 5'b10000;
        ext_brk_n = 1'b0; expect_brk(cyc + 3, 1'b0, "R9 ext fall");
        repeat (6) @(negedge clk);
        ext_brk_n = 1'b1;
        quiet(4, "R9 single");

        // R11 run low
        phase = "R11"; src_en = 5'b10001; run = 1'b0;
        ext_brk_n = 1'b0;
        do_fetch(16'h0200, 1'b0, "R11");
        repeat (4) @(negedge clk);
        ext_brk_n = 1'b1;
        repeat (4) @(negedge clk);
        run = 1'b1;
        quiet(3, "R11 stopped");

        // R10 deferral during interrupt acknowledge
        phase = "R10"; src_en = 5'b00001; irq_ack_n = 1'b0;
        do_fetch(16'h0200, 1'b0, "R10");
        repeat (3) @(negedge clk);
        irq_ack_n = 1'b1; expect_brk(cyc + 1, 1'b1, "R10 release");
        quiet(3, "R10 release");
        src_en = 5'b00100; irq_ack_n = 1'b0;
        do_dacc(16'h0041, 4'hA, 1'b1, 1'b0, "R10");
        @(negedge clk);
        irq_ack_n = 1'b1; expect_brk(cyc + 1, 1'b1, "R10 data held as pre");
        quiet(3, "R10 after");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule